// File: doc/BRIEF.md
# Sysreg Load/Store Address Generator

This block forms the memory address and the base-register update for instructions that move a floating-point system register straight to or from memory. Each request carries a base register value and its index, an unsigned immediate, an add/subtract selector, a pre-index flag and a writeback flag. The address generator scales the immediate to a byte offset and applies it to the base. It also rejects encodings that are not legal, applies an optional stack-limit test and enforces word alignment.

The result is registered and returned on a valid/ready handshake towards the register unit. The response holds the word-access address, a memory request strobe, the writeback value with its target index and enable, and three fault flags. A fault of any kind withdraws both the memory request and the writeback. For a store, the data reaches memory before the register unit commits any base update. That order is kept because the writeback is only committed by the consumer after it has seen the response, and a faulting response carries no writeback.

Top module: `sysreg_agu`

## Requirements
- R1: When the feature strap `feat_v81` is low, the response raises `flt_undef` and drives `mem_req` and `wb_en` low.
- R2: A base index equal to 15 raises `flt_undef` with `mem_req` and `wb_en` low, whatever the other fields are.
- R3: The byte offset is `imm` multiplied by 4. It is added to the base when `off_add` is 1 and subtracted when `off_add` is 0, modulo 2^32.
- R4: With `pre_idx` set, `mem_addr` is the offset address. With `pre_idx` clear, `mem_addr` is the unmodified base.
- R5: With `wback` set and no fault, `wb_en` is 1, `wb_data` is the offset address (for both pre- and post-index) and `wb_idx` is the base index. With `wback` clear, `wb_en` is 0.
- R6: An access address whose two low bits are not 00 raises `flt_align` and clears `mem_req` and `wb_en`. An aligned access with no other fault raises `mem_req`.
- R7: When `stk_chk_en` is 1, the base index is 13 and `wback` is 1, an access address strictly below `stk_limit` (unsigned) raises `flt_stack` and clears `mem_req` and `wb_en`. An address equal to the limit passes. Without all three conditions, no stack fault is raised.
- R8: At most one fault flag is high. The priority is undefined encoding, then stack limit, then alignment.
- R9: `req_ready` equals `!rsp_valid || rsp_ready`. A request accepted at a clock edge is presented with `rsp_valid` high right after that edge.
- R10: While `rsp_valid` is high and `rsp_ready` is low, every response output holds its value.
- R11: During and right after reset, `rsp_valid`, `mem_req`, `wb_en` and all fault flags are 0. When a response is taken with no new request, they return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| base_val | input | 32 | Base register value |
| base_idx | input | 4 | Base register index |
| imm | input | 8 | Unscaled offset immediate |
| off_add | input | 1 | 1 adds the offset, 0 subtracts it |
| pre_idx | input | 1 | 1 uses the offset address for the access |
| wback | input | 1 | 1 writes the offset address back to the base |
| stk_limit | input | 32 | Stack limit for the overflow test |
| stk_chk_en | input | 1 | Enables the stack-limit test |
| feat_v81 | input | 1 | Feature strap; the encoding is illegal when low |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Register unit takes the response |
| mem_addr | output | 32 | Word-access address |
| mem_req | output | 1 | Word-access request |
| wb_data | output | 32 | Value for the base register |
| wb_idx | output | 4 | Index of the base register |
| wb_en | output | 1 | Base writeback enable |
| flt_undef | output | 1 | Encoding is undefined |
| flt_stack | output | 1 | Stack-limit violation |
| flt_align | output | 1 | Misaligned access |

## Verification
The bench builds the block with its default parameters: a 32-bit address, an 8-bit immediate scaled by 4, stack pointer index 13 and the stack test present. With these values the largest offset of 1020 bytes is reachable, and bases near zero and near the top of the address space make the add and subtract wrap observable. Limits equal to and one above the access address probe the strict compare. Stalls driven on `rsp_ready` exercise both the hold rule and back-to-back acceptance.

// File: rtl/sysreg_agu_pkg.sv
package sysreg_agu_pkg;
  typedef struct packed {
    logic undef;
    logic stack;
    logic align;
  } agu_flt_t;
endpackage

// File: rtl/sysreg_agu_addr.sv
module sysreg_agu_addr #(
  parameter int AW        = 32,
  parameter int IMM_W     = 8,
  parameter int OFF_SHIFT = 2
) (
  input  logic [AW-1:0]    base_val,
  input  logic [IMM_W-1:0] imm,
  input  logic             off_add,
  input  logic             pre_idx,
  output logic [AW-1:0]    off_addr,
  output logic [AW-1:0]    acc_addr
);
  localparam int PAD_W = AW - IMM_W;

  logic [AW-1:0] off_bytes;

  assign off_bytes = {{PAD_W{1'b0}}, imm} << OFF_SHIFT;

  always_comb begin
    if (off_add) off_addr = base_val + off_bytes;
    else         off_addr = base_val - off_bytes;
    acc_addr = pre_idx ? off_addr : base_val;
  end
endmodule

// File: rtl/sysreg_agu_chk.sv
module sysreg_agu_chk
  import sysreg_agu_pkg::*;
#(
  parameter int AW        = 32,
  parameter int RIDX_W    = 4,
  parameter int SP_IDX    = 13,
  parameter int PC_IDX    = 15,
  parameter int ALIGN_LSB = 2,
  parameter bit HAS_STK   = 1'b1
) (
  input  logic              feat_v81,
  input  logic [RIDX_W-1:0] base_idx,
  input  logic              wback,
  input  logic              stk_chk_en,
  input  logic [AW-1:0]     acc_addr,
  input  logic [AW-1:0]     stk_limit,
  output agu_flt_t          flt,
  output logic              go_mem,
  output logic              go_wb
);
  localparam logic [RIDX_W-1:0] SP_CODE = RIDX_W'(SP_IDX);
  localparam logic [RIDX_W-1:0] PC_CODE = RIDX_W'(PC_IDX);

  logic bad_enc;
  logic stk_hit;
  logic mis;

  assign bad_enc = !feat_v81 || (base_idx == PC_CODE);

  generate
    if (HAS_STK) begin : g_stk
      assign stk_hit = stk_chk_en && wback && (base_idx == SP_CODE) &&
                       (acc_addr < stk_limit);
    end else begin : g_nostk
      assign stk_hit = 1'b0;
    end
  endgenerate

  assign mis = |acc_addr[ALIGN_LSB-1:0];

  always_comb begin
    flt.undef = bad_enc;
    flt.stack = !bad_enc && stk_hit;
    flt.align = !bad_enc && !stk_hit && mis;
    go_mem    = !(flt.undef || flt.stack || flt.align);
    go_wb     = go_mem && wback;
  end
endmodule

// File: rtl/sysreg_agu_pipe.sv
module sysreg_agu_pipe
  import sysreg_agu_pkg::*;
#(
  parameter int AW     = 32,
  parameter int RIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [AW-1:0]     in_addr,
  input  logic [AW-1:0]     in_wbd,
  input  logic [RIDX_W-1:0] in_idx,
  input  logic              in_req,
  input  logic              in_wbe,
  input  agu_flt_t          in_flt,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [AW-1:0]     out_addr,
  output logic [AW-1:0]     out_wbd,
  output logic [RIDX_W-1:0] out_idx,
  output logic              out_req,
  output logic              out_wbe,
  output agu_flt_t          out_flt
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_wbd   <= '0;
      out_idx   <= '0;
      out_req   <= 1'b0;
      out_wbe   <= 1'b0;
      out_flt   <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_addr  <= in_addr;
      out_wbd   <= in_wbd;
      out_idx   <= in_idx;
      out_req   <= in_req;
      out_wbe   <= in_wbe;
      out_flt   <= in_flt;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      out_req   <= 1'b0;
      out_wbe   <= 1'b0;
      out_flt   <= '0;
    end
  end

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_req) &&
                                   $stable(out_wbe) && $stable(out_flt) && $stable(out_wbd))); // R10
  AST_REQ_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    (out_req || out_wbe || (|out_flt)) |-> out_valid); // R11
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid); // R9
endmodule

// File: rtl/sysreg_agu.sv
module sysreg_agu
  import sysreg_agu_pkg::*;
#(
  parameter int AW        = 32,
  parameter int IMM_W     = 8,
  parameter int OFF_SHIFT = 2,
  parameter int RIDX_W    = 4,
  parameter int SP_IDX    = 13,
  parameter int PC_IDX    = 15,
  parameter bit HAS_STK   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     base_val,
  input  logic [RIDX_W-1:0] base_idx,
  input  logic [IMM_W-1:0]  imm,
  input  logic              off_add,
  input  logic              pre_idx,
  input  logic              wback,
  input  logic [AW-1:0]     stk_limit,
  input  logic              stk_chk_en,
  input  logic              feat_v81,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_req,
  output logic [AW-1:0]     wb_data,
  output logic [RIDX_W-1:0] wb_idx,
  output logic              wb_en,
  output logic              flt_undef,
  output logic              flt_stack,
  output logic              flt_align
);
  localparam int ALIGN_LSB = 2;

  logic [AW-1:0] off_addr;
  logic [AW-1:0] acc_addr;
  agu_flt_t      c_flt;
  agu_flt_t      r_flt;
  logic          c_go_mem;
  logic          c_go_wb;

  sysreg_agu_addr #(.AW(AW), .IMM_W(IMM_W), .OFF_SHIFT(OFF_SHIFT)) u_addr (
    .base_val (base_val),
    .imm      (imm),
    .off_add  (off_add),
    .pre_idx  (pre_idx),
    .off_addr (off_addr),
    .acc_addr (acc_addr)
  );

  sysreg_agu_chk #(.AW(AW), .RIDX_W(RIDX_W), .SP_IDX(SP_IDX), .PC_IDX(PC_IDX),
                   .ALIGN_LSB(ALIGN_LSB), .HAS_STK(HAS_STK)) u_chk (
    .feat_v81   (feat_v81),
    .base_idx   (base_idx),
    .wback      (wback),
    .stk_chk_en (stk_chk_en),
    .acc_addr   (acc_addr),
    .stk_limit  (stk_limit),
    .flt        (c_flt),
    .go_mem     (c_go_mem),
    .go_wb      (c_go_wb)
  );

  sysreg_agu_pipe #(.AW(AW), .RIDX_W(RIDX_W)) u_pipe (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_addr   (acc_addr),
    .in_wbd    (off_addr),
    .in_idx    (base_idx),
    .in_req    (c_go_mem),
    .in_wbe    (c_go_wb),
    .in_flt    (c_flt),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_addr  (mem_addr),
    .out_wbd   (wb_data),
    .out_idx   (wb_idx),
    .out_req   (mem_req),
    .out_wbe   (wb_en),
    .out_flt   (r_flt)
  );

  assign flt_undef = r_flt.undef;
  assign flt_stack = r_flt.stack;
  assign flt_align = r_flt.align;

  AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (rst)
    flt_undef |-> (!mem_req && !wb_en)); // R1
  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[ALIGN_LSB-1:0] == '0)); // R6
  AST_ONE_FAULT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({flt_undef, flt_stack, flt_align})); // R8
  AST_WB_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> mem_req); // R5
  AST_STACK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    flt_stack |-> (!mem_req && !wb_en)); // R7
endmodule

// File: tb/tb_sysreg_agu.sv
`timescale 1ns/1ps
module tb_sysreg_agu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] base_val = '0;
  logic [3:0]  base_idx = '0;
  logic [7:0]  imm = '0;
  logic        off_add = 1'b0, pre_idx = 1'b0, wback = 1'b0;
  logic [31:0] stk_limit = '0;
  logic        stk_chk_en = 1'b0, feat_v81 = 1'b1;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] mem_addr, wb_data;
  logic        mem_req, wb_en;
  logic [3:0]  wb_idx;
  logic        flt_undef, flt_stack, flt_align;

  int checks = 0;
  int errors = 0;
  int rdy_mode = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sysreg_agu dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .base_val(base_val), .base_idx(base_idx), .imm(imm), .off_add(off_add),
    .pre_idx(pre_idx), .wback(wback), .stk_limit(stk_limit), .stk_chk_en(stk_chk_en),
    .feat_v81(feat_v81), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .mem_addr(mem_addr), .mem_req(mem_req), .wb_data(wb_data), .wb_idx(wb_idx),
    .wb_en(wb_en), .flt_undef(flt_undef), .flt_stack(flt_stack), .flt_align(flt_align)
  );

  // Reference model state
  bit          m_valid, m_req, m_wbe, m_und, m_stk, m_aln;
  logic [31:0] m_addr, m_wbd;
  logic [3:0]  m_idx;

  always @(posedge clk) begin
    if (rst) begin
      m_valid = 0; m_req = 0; m_wbe = 0; m_und = 0; m_stk = 0; m_aln = 0;
    end else if (req_valid && (!m_valid || rsp_ready)) begin
      longint unsigned off;
      logic [31:0] oa;
      off = longint'(imm) * 4;
      oa  = off_add ? base_val + 32'(off) : base_val - 32'(off);
      m_addr  = pre_idx ? oa : base_val;
      m_wbd   = oa;
      m_idx   = base_idx;
      m_und   = !feat_v81 || base_idx == 4'd15;
      m_stk   = !m_und && stk_chk_en && base_idx == 4'd13 && wback && (m_addr < stk_limit);
      m_aln   = !m_und && !m_stk && (m_addr % 4 != 0);
      m_req   = !(m_und || m_stk || m_aln);
      m_wbe   = m_req && wback;
      m_valid = 1;
    end else if (rsp_ready) begin
      m_valid = 0; m_req = 0; m_wbe = 0; m_und = 0; m_stk = 0; m_aln = 0;
    end
  end

  task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", rq, $time, act, exp);
    end
  endtask

  // Compare every clock, at the falling edge (inputs change 1 ns later)
  always @(negedge clk) begin
    if (!done) begin
      if (rst) begin
        chk(!rsp_valid && !mem_req && !wb_en, "R11 reset outputs", {rsp_valid, mem_req, wb_en}, 0);
        chk({flt_undef, flt_stack, flt_align} == 0, "R11 reset flags",
            {flt_undef, flt_stack, flt_align}, 0);
      end else begin
        chk(rsp_valid == m_valid, "R9,R10,R11 rsp_valid", rsp_valid, m_valid);
        chk(req_ready == (!m_valid || rsp_ready), "R9 req_ready", req_ready, !m_valid || rsp_ready);
        chk(flt_undef == m_und, "R1,R2 flt_undef", flt_undef, m_und);
        chk(flt_stack == m_stk, "R7 flt_stack", flt_stack, m_stk);
        chk(flt_align == m_aln, "R6 flt_align", flt_align, m_aln);
        chk(mem_req == m_req, "R6 mem_req", mem_req, m_req);
        chk(wb_en == m_wbe, "R5 wb_en", wb_en, m_wbe);
        chk(32'($countones({flt_undef, flt_stack, flt_align})) <= 1, "R8 one fault",
            {flt_undef, flt_stack, flt_align}, 0);
        if (m_valid) chk(mem_addr == m_addr, "R3,R4 mem_addr", mem_addr, m_addr);
        if (m_wbe) begin
          chk(wb_data == m_wbd, "R3,R5 wb_data", wb_data, m_wbd);
          chk(wb_idx == m_idx, "R5 wb_idx", wb_idx, m_idx);
        end
      end
    end
  end

  // Response-side readiness pattern: 0 always ready, 1 alternating, 2 pseudo-random
  int cyc = 0;
  always @(negedge clk) begin
    #1;
    cyc++;
    case (rdy_mode)
      0: rsp_ready = 1'b1;
      1: rsp_ready = cyc[0];
      default: rsp_ready = ($urandom % 3) != 0;
    endcase
  end

  task automatic issue(input logic [3:0] idx, input logic [31:0] b, input logic [7:0] im,
                       input bit ad, input bit pr, input bit wb,
                       input logic [31:0] lim, input bit en, input bit v81);
    @(negedge clk); #1;
    base_idx = idx; base_val = b; imm = im; off_add = ad; pre_idx = pr; wback = wb;
    stk_limit = lim; stk_chk_en = en; feat_v81 = v81; req_valid = 1'b1;
    forever begin
      #1;
      if (req_ready) break;
      @(negedge clk); #1;
    end
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk); #1;
    req_valid = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1 rst = 1'b0;
    // R3 R4 R5: pre-index add with writeback
    issue(4'd2, 32'h0000_1000, 8'd5, 1, 1, 1, 0, 0, 1);
    // R4 R5: post-index subtract with writeback
    issue(4'd3, 32'h0000_2000, 8'd3, 0, 0, 1, 0, 0, 1);
    // R5: no writeback
    issue(4'd4, 32'h0000_3000, 8'd7, 1, 1, 0, 0, 0, 1);
    // R1: feature strap low
    issue(4'd1, 32'h0000_4000, 8'd1, 1, 1, 1, 0, 0, 0);
    // R2: base index 15
    issue(4'd15, 32'h0000_5000, 8'd1, 1, 1, 1, 0, 0, 1);
    // R6: misaligned base, post-index
    issue(4'd5, 32'h0000_1002, 8'd4, 1, 0, 1, 0, 0, 1);
    // R7: stack overflow below limit, then equal to limit passes
    issue(4'd13, 32'h0000_0100, 8'h10, 0, 1, 1, 32'h0000_0100, 1, 1);
    issue(4'd13, 32'h0000_0100, 8'h10, 0, 1, 1, 32'h0000_00C0, 1, 1);
    issue(4'd13, 32'h0000_0100, 8'h10, 0, 1, 1, 32'h0000_00C1, 1, 1);
    // R8: misaligned and below limit reports only the stack fault
    issue(4'd13, 32'h0000_0102, 8'h00, 1, 1, 1, 32'h0000_0200, 1, 1);
    // R7: no stack test without writeback, with another base, or disabled
    issue(4'd13, 32'h0000_0100, 8'h00, 1, 1, 0, 32'h0000_0200, 1, 1);
    issue(4'd12, 32'h0000_0100, 8'h00, 1, 1, 1, 32'h0000_0200, 1, 1);
    issue(4'd13, 32'h0000_0100, 8'h00, 1, 1, 1, 32'h0000_0200, 0, 1);
    // R8: undefined wins over stack and alignment
    issue(4'd13, 32'h0000_0102, 8'h00, 1, 1, 1, 32'h0000_0200, 1, 0);
    // R3: wrap below zero and above the top, largest offset
    issue(4'd6, 32'h0000_0000, 8'd1, 0, 1, 1, 0, 0, 1);
    issue(4'd7, 32'hFFFF_FF00, 8'hFF, 1, 1, 1, 0, 0, 1);
    idle(2);
    // R10: alternating stalls with back-to-back requests
    rdy_mode = 1;
    for (int i = 0; i < 12; i++)
      issue(4'(i), 32'h0000_8000 + 32'(i * 4), 8'(i), i[0], i[1], 1, 0, 0, 1);
    idle(3);
    // R9 R10: pseudo-random stream
    rdy_mode = 2;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] b;
      b = $urandom;
      if (i % 3 != 0) b[1:0] = 2'b00;
      issue(4'($urandom), b, 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            b + 32'($urandom % 2048) - 32'd1024, 1'($urandom), ($urandom % 8) != 0);
      if (i % 17 == 0) idle(2);
    end
    idle(4);
    rdy_mode = 0;
    idle(4);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule